// File: doc/BRIEF.md
# Companded PCM Sample Player

The player streams stored audio samples out of a 32 KiB sample region to an 8-bit audio output register. Software picks a first page and a last page (256 bytes each) and a mode, then pulses `start`. After that, every pulse of the audio block tick either produces a new output sample or is skipped, depending on the mode. Playback runs until the final byte of the last page has been used. After that the player reports completion and drives silence.

The mode code has three bits. Codes 0 to 3 stand for silence and the tone-voice settings, and they leave the player idle. Codes 4 to 7 select PCM playback. Bit 0 of the mode chooses 4-bit companded samples, two per byte with the high nibble played first. Bit 1 chooses half rate, where every second tick is skipped. A companded nibble is a sign bit followed by a 3-bit exponent, and it expands into a run of ones: positive code n gives 2^n-1, and negative codes give a left-shifted 0xFF.

The sample memory has one synchronous read port. Data for a read asserted in cycle T is presented during cycle T+1. Ticks must be at least two cycles apart.

Top module: `pcm_player`

## Requirements
- R1: A `start` pulse with mode bit 2 set latches the mode and both pages. In the next cycle `playing`=1, `finished`=0, and `rd_addr` points at offset 0 of the first page.
- R2: A `start` pulse with mode 0 to 3 has no effect. It does not start, stop or restart playback, and it leaves `pcm_out` unchanged.
- R3: After reset, `playing`, `finished` and `pcm_out` are 0. A tick that arrives while not playing sets `pcm_out` to 0x00 two cycles after the tick cycle.
- R4: In 8-bit modes (4 and 6), each played tick asserts `rd_en` during the tick cycle at the next byte address. The byte read appears unchanged on `pcm_out` two cycles after the tick.
- R5: In 4-bit modes (5 and 7), the high nibble (bits 7:4) is played first and the low nibble (bits 3:0) second. A read is issued only on the tick that plays a high nibble, and the address steps by one byte after each low nibble.
- R6: Nibble codes 0 to 7 expand to 0x00, 0x01, 0x03, 0x07, 0x0F, 0x1F, 0x3F and 0x7F.
- R7: Nibble codes 8 to 15 (that is, -8 to -1) expand to 0x80, 0xC0, 0xE0, 0xF0, 0xF8, 0xFC, 0xFE and 0xFF.
- R8: In half-rate modes (6 and 7), the first tick after start plays and the ticks after it alternate between skip and play. A skipped tick issues no read and leaves `pcm_out` unchanged.
- R9: The tick that uses the last byte of the last page (in 4-bit modes, its low nibble) clears `playing` and sets `finished` one cycle later. No reads follow, and later ticks give 0x00. The byte address wraps modulo 32 KiB, so a last page below the first page plays through the wrap.
- R10: A PCM `start` while a sample is in flight discards that sample and restarts from the new first page. When `start` and a tick fall in the same cycle, the tick is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Mode code, sampled on `start` |
| first_page | input | 7 | Page where playback begins |
| last_page | input | 7 | Page holding the final byte played |
| start | input | 1 | One-cycle start or restart pulse |
| blk_tick | input | 1 | Audio block strobe |
| rd_en | output | 1 | Sample memory read enable |
| rd_addr | output | 15 | Sample memory byte address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| pcm_out | output | 8 | Audio output register |
| playing | output | 1 | Playback in progress |
| finished | output | 1 | Last byte used, cleared by the next PCM start |

## Verification
`rd_en` and `rd_addr` are combinational in the tick cycle. `playing` and `finished` change one edge after the tick or start that moves them. A new `pcm_out` value appears two edges after its tick, because the read and the expansion each take one register stage. The bench model keeps a queue of expected output values, each stamped with the edge at which it becomes due. A start empties that queue, so in-flight samples are discarded. Inputs change just after a rising edge, and every output is compared against the model at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/pcm_player.sv
module pcm_player #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-9:0] first_page,
  input  logic [ADDR_W-9:0] last_page,
  input  logic              start,
  input  logic              blk_tick,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic [7:0]        pcm_out,
  output logic              playing,
  output logic              finished
);
  localparam int PW = ADDR_W - 8;

  logic              nib4_r, half_r, lo_r, phase_r;
  logic              pend_r, pend_zero_r, pend_fetch_r;
  logic [ADDR_W-1:0] addr_r;
  logic [PW-1:0]     stop_r;
  logic [7:0]        byte_r;

  function automatic logic [7:0] expand(input logic [3:0] c);
    return c[3] ? (8'hFF << (~c[2:0])) : ((8'h01 << c[2:0]) - 8'h01);
  endfunction

  wire go_pcm = start & mode[2];
  wire play   = blk_tick & playing & ~go_pcm & ~(half_r & phase_r);
  wire step   = play & ~(nib4_r & ~lo_r);
  wire last   = step & (addr_r[7:0] == 8'hFF) & (addr_r[ADDR_W-1:8] == stop_r);

  assign rd_en   = play & ~(nib4_r & lo_r);
  assign rd_addr = addr_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      playing <= 1'b0; finished <= 1'b0;
      nib4_r <= 1'b0; half_r <= 1'b0; lo_r <= 1'b0; phase_r <= 1'b0;
      pend_r <= 1'b0; pend_zero_r <= 1'b0; pend_fetch_r <= 1'b0;
      addr_r <= '0; stop_r <= '0; byte_r <= '0; pcm_out <= '0;
    end else begin
      pend_r       <= blk_tick & ~go_pcm & (play | ~playing);
      pend_zero_r  <= ~playing;
      pend_fetch_r <= rd_en;
      if (go_pcm) begin
        playing <= 1'b1; finished <= 1'b0;
        nib4_r <= mode[0]; half_r <= mode[1];
        lo_r <= 1'b0; phase_r <= 1'b0;
        addr_r <= {first_page, 8'h00};
        stop_r <= last_page;
      end else if (blk_tick && playing) begin
        if (half_r && phase_r) phase_r <= 1'b0;
        else begin
          phase_r <= half_r;
          lo_r    <= nib4_r & ~lo_r;
          if (step) addr_r <= addr_r + 1'b1;
          if (last) begin playing <= 1'b0; finished <= 1'b1; end
        end
      end
      if (pend_r && !go_pcm) begin
        if (pend_zero_r)       pcm_out <= 8'h00;
        else if (!nib4_r)      pcm_out <= rd_data;
        else if (pend_fetch_r) begin byte_r <= rd_data; pcm_out <= expand(rd_data[7:4]); end
        else                   pcm_out <= expand(byte_r[3:0]);
      end
    end
  end

  AST_START_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    go_pcm |=> playing && !finished && rd_addr[7:0] == 8'h00); // R1
  AST_NON_PCM_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mode[2] && !playing && !blk_tick) |=> !playing); // R2
  AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_tick && playing && half_r && phase_r && !go_pcm) |=> ##1 $stable(pcm_out)); // R8
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> !playing); // R9
  AST_NO_READ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> !rd_en); // R9
endmodule

// File: tb/test_pcm_player.sv
module test_pcm_player;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = '0;
  logic [6:0] first_page = '0, last_page = '0;
  logic start = 1'b0, blk_tick = 1'b0;
  logic rd_en;
  logic [14:0] rd_addr;
  logic [7:0] rd_data = '0;
  logic [7:0] pcm_out;
  logic playing, finished;

  always #10 clk = ~clk;

  pcm_player i_pcm_player (
    .clk(clk), .rst_n(rst_n), .mode(mode), .first_page(first_page),
    .last_page(last_page), .start(start), .blk_tick(blk_tick),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pcm_out(pcm_out), .playing(playing), .finished(finished));

  function automatic int mf(input int a);
    return (a * 73 + (a >> 7) * 11 + 5) % 256;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= 8'(mf(int'(rd_addr)));

  // run-of-ones expansion, written independently: R6 R7
  function automatic int dec(input int c);
    int v;
    if (c < 8) begin v = 0; repeat (c) v = v * 2 + 1; end
    else begin v = 255; repeat (15 - c) v = (v * 2) % 256; end
    return v;
  endfunction

  int n_cmp = 0, n_bad = 0;
  string tag = "R3";
  bit all_done = 0;

  int m_busy, m_done, m_ptr, m_stop, m4, mh, m_lo, m_ph, exp_out, cnt;
  int qdue[$], qval[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ptr = 0; m_stop = 0; m4 = 0; mh = 0;
      m_lo = 0; m_ph = 0; exp_out = 0; cnt = 0;
      qdue.delete(); qval.delete();
    end else begin
      cnt++;
      if (start && mode[2]) begin
        qdue.delete(); qval.delete();
        m_busy = 1; m_done = 0; m_ptr = first_page * 256; m_stop = last_page;
        m4 = mode[0]; mh = mode[1]; m_lo = 0; m_ph = 0;
      end else begin
        while (qdue.size() > 0 && qdue[0] == cnt) begin
          exp_out = qval[0]; void'(qdue.pop_front()); void'(qval.pop_front());
        end
        if (blk_tick) begin
          if (!m_busy) begin qdue.push_back(cnt + 1); qval.push_back(0); end
          else if (mh && m_ph) m_ph = 0;
          else begin
            int b, v, used;
            m_ph = mh; b = mf(m_ptr); used = 1;
            if (!m4) v = b;
            else if (!m_lo) begin v = dec(b / 16); m_lo = 1; used = 0; end
            else begin v = dec(b % 16); m_lo = 0; end
            qdue.push_back(cnt + 1); qval.push_back(v);
            if (used) begin
              if (m_ptr % 256 == 255 && m_ptr / 256 == m_stop) begin m_busy = 0; m_done = 1; end
              m_ptr = (m_ptr + 1) % 32768;
            end
          end
        end
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !all_done) begin
    int erd;
    erd = (blk_tick && m_busy && !(start && mode[2]) && !(mh && m_ph) && !(m4 && m_lo)) ? 1 : 0;
    chk("pcm_out", int'(pcm_out), exp_out);
    chk("playing", int'(playing), m_busy);
    chk("finished", int'(finished), m_done);
    chk("rd_en", int'(rd_en), erd);
    if (erd) chk("rd_addr", int'(rd_addr), m_ptr);
  end

  task automatic cyc(input logic b, input logic g);
    @(posedge clk); #1; blk_tick = b; start = g;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin cyc(1, 0); cyc(0, 0); cyc(0, 0); end
  endtask
  task automatic go(input int m, input int f, input int l);
    mode = 3'(m); first_page = 7'(f); last_page = 7'(l); cyc(0, 1); cyc(0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tag = "R3"; cyc(0, 0); ticks(4);                 // reset state, idle ticks give zero
    tag = "R2"; go(2, 1, 1); ticks(3);               // tone mode start ignored
    tag = "R4 R1"; go(4, 2, 2); ticks(256);
    tag = "R9"; ticks(4);                            // silence after end
    tag = "R5 R6 R7"; go(5, 5, 6); ticks(1024 + 4);
    tag = "R8"; go(6, 10, 10); ticks(512 + 4);
    tag = "R8 R5"; go(7, 20, 20); ticks(1024 + 4);
    tag = "R2"; go(4, 3, 3); ticks(20); go(1, 9, 9); ticks(10);
    tag = "R10"; cyc(1, 0); cyc(0, 1); mode = 3'd5; first_page = 7'd7; last_page = 7'd7;
    cyc(0, 0); ticks(15);
    mode = 3'd4; first_page = 7'd8; cyc(1, 1); cyc(0, 0); ticks(10);
    tag = "R9"; go(4, 127, 0); ticks(512 + 4);      // wrap through top of region
    cyc(0, 0); cyc(0, 0);
    all_done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!all_done) begin
      all_done = 1; n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule